// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block brings an asynchronous EDO DRAM array out of power-up and keeps its contents alive afterwards. The array has one row strobe and four byte-lane column strobes. From reset the block counts a fixed pause. It then runs a series of warm-up refresh cycles and only then declares the memory usable. From that point on it schedules one refresh per row slot. The interval is the retention period divided by the row count, rounded down to whole clocks.

Each refresh is a column-before-row cycle that the block drives on the strobe pins itself. The lengths of all phases come from nanosecond minimums. Each minimum is turned into a clock count by rounding up against a clock-period parameter. The access sequencer shares the pins. The block asks for them with `bus_req` and waits for `bus_gnt`. While `bus_own` is high, the sequencer must route this block's strobes to the pins. When the block is idle it parks its own strobes high.

Top module: `dram_refresh_sched`

## Requirements
- R1: From reset release, `bus_req` stays low and all strobes stay high for `ceil(INIT_NS*1000/CLK_PS)` clock cycles.
- R2: After the pause, exactly `WARM_N` refresh cycles are requested and run back to back through the handshake, with no interval wait between them.
- R3: `ready` is low from reset until the clock edge that ends the last warm-up cycle. From then on it stays high.
- R4: Once `ready` is high, a refresh falls due every `floor(RETAIN_NS/ROWS*1000/CLK_PS)` cycles. A due refresh is held pending until it is served. Dues that arrive while one is already pending merge into a single refresh.
- R5: In every refresh, all column strobes (`cas_n`, all bits 0) go low S cycles before `ras_n` falls and stay low for H cycles after it. S = ceil(max(5 ns, 10 ns)/period) and H = ceil(max(10 ns, 10 ns)/period). `ras_n` stays low for max(ceil(50 ns/period), H+1) cycles.
- R6: `we_n` is high in every cycle, including throughout each refresh.
- R7: `bus_req` rises one cycle after a refresh is needed and holds until the refresh ends. The strobes start moving on the cycle after `bus_gnt` is sampled high. `bus_own` is high exactly during the strobe sequence.
- R8: After `ras_n` rises, all strobes stay high for max(ceil(30 ns/period), ceil(84 ns/period) − row-low cycles) cycles before the bus is released. This keeps row-fall to row-fall at or above the row cycle time.
- R9: While reset is asserted, `bus_req`, `bus_own` and `ready` are low, and `ras_n`, `cas_n` and `we_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PS picoseconds |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Access sequencer hands the strobe pins to this block |
| bus_req | output | 1 | Request for the strobe pins |
| bus_own | output | 1 | Strobe outputs of this block are live |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | LANES | Byte-lane column strobes, active low |
| we_n | output | 1 | Write enable, active low, held high |
| ready | output | 1 | Initialization finished, memory usable |

## Verification
The bench runs a behavioural reference model on each rising edge and compares every output on the following falling edge. As a result, each expected change is checked in the exact cycle it is due. `bus_req` is checked one edge after a need appears. The strobes are checked from the edge after `bus_gnt` is seen, with the model's position in the cycle at S, S+H, S+R and S+R+P. `ready` is checked on the edge that closes the final warm-up precharge. The pause end is checked `INIT` edges after reset release. Interval dues are checked every `INTV` edges once ready. The grant is delayed by 0 to 170 cycles, so both back-to-back refreshes and merged dues are exercised against those fixed latencies.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [1:0] {PH_PAUSE, PH_WARM, PH_RUN} phase_t;

   typedef enum logic [2:0] {
      EN_IDLE, EN_REQ, EN_SETUP, EN_HOLD, EN_RASLO, EN_PRE
   } eng_t;

   // nanoseconds to whole clocks, rounded up, never below one
   function automatic int ns_to_cyc(input int ns, input int clk_ps);
      int c;
      c = (ns * 1000 + clk_ps - 1) / clk_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rfsh_tick_timer.sv
module rfsh_tick_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int W = $clog2(LIMIT) + 1;

   if (LIMIT < 1) begin : g_bad_limit
      $error("rfsh_tick_timer: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt;

   assign tick = en && (cnt == W'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (en)  cnt <= tick ? '0 : cnt + 1'b1;
   end

   // tick pulses can never come on consecutive cycles unless LIMIT is one
   assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (LIMIT > 1 && tick) |=> !tick);

endmodule

// File: rtl/rfsh_cbr_engine.sv
module rfsh_cbr_engine
   import dram_rfsh_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int SETUP_C = 1,
   parameter int HOLD_C  = 1,
   parameter int RAS_C   = 5,
   parameter int PRE_C   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             need,
   input  logic             bus_gnt,
   output logic             bus_req,
   output logic             bus_own,
   output logic             ras_n,
   output logic [LANES-1:0] cas_n,
   output logic             we_n,
   output logic             start,
   output logic             done
);
   localparam int MAXC = imax(imax(SETUP_C, HOLD_C), imax(RAS_C, PRE_C));
   localparam int CW   = $clog2(MAXC + 1);

   if (RAS_C <= HOLD_C) begin : g_bad_ras
      $error("rfsh_cbr_engine: row-low time must exceed column hold");
   end
   if (SETUP_C < 1 || PRE_C < 1 || LANES < 1) begin : g_bad_cfg
      $error("rfsh_cbr_engine: phase counts and lane count must be positive");
   end

   eng_t          st;
   logic [CW-1:0] cnt;
   logic          cas_low;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= EN_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            EN_IDLE: if (need) st <= EN_REQ;
            EN_REQ:  if (bus_gnt) begin
                        st  <= EN_SETUP;
                        cnt <= CW'(SETUP_C - 1);
                     end
            EN_SETUP: if (cnt == '0) begin
                        st  <= EN_HOLD;
                        cnt <= CW'(HOLD_C - 1);
                     end else cnt <= cnt - 1'b1;
            EN_HOLD: if (cnt == '0) begin
                        st  <= EN_RASLO;
                        cnt <= CW'(RAS_C - HOLD_C - 1);
                     end else cnt <= cnt - 1'b1;
            EN_RASLO: if (cnt == '0) begin
                        st  <= EN_PRE;
                        cnt <= CW'(PRE_C - 1);
                     end else cnt <= cnt - 1'b1;
            EN_PRE:  if (cnt == '0) st <= EN_IDLE;
                     else cnt <= cnt - 1'b1;
            default: st <= EN_IDLE;
         endcase
      end
   end

   assign bus_req = (st != EN_IDLE);
   assign bus_own = (st == EN_SETUP) || (st == EN_HOLD) ||
                    (st == EN_RASLO) || (st == EN_PRE);
   assign cas_low = (st == EN_SETUP) || (st == EN_HOLD);
   assign ras_n   = !((st == EN_HOLD) || (st == EN_RASLO));
   assign we_n    = 1'b1;
   assign start   = (st == EN_REQ) && bus_gnt;
   assign done    = (st == EN_PRE) && (cnt == '0);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign cas_n[i] = !cas_low;
   end

   assert_cas_before_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (cas_n == '0) && $past(cas_n == '0));

   assert_cas_high_at_ras_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (&cas_n));

   assert_own_follows_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_own) |-> $past(bus_gnt));

   assert_own_under_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_own |-> bus_req);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import dram_rfsh_pkg::*;
#(
   parameter int CLK_PS    = 10000,
   parameter int LANES     = 4,
   parameter int INIT_NS   = 200000,
   parameter int WARM_N    = 8,
   parameter int ROWS      = 4096,
   parameter int RETAIN_NS = 64000000,
   parameter int T_CSR_NS  = 5,
   parameter int T_CHR_NS  = 10,
   parameter int T_WRP_NS  = 10,
   parameter int T_WRH_NS  = 10,
   parameter int T_RAS_NS  = 50,
   parameter int T_RP_NS   = 30,
   parameter int T_RC_NS   = 84
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_gnt,
   output logic             bus_req,
   output logic             bus_own,
   output logic             ras_n,
   output logic [LANES-1:0] cas_n,
   output logic             we_n,
   output logic             ready
);
   localparam int INIT_C  = ns_to_cyc(INIT_NS, CLK_PS);
   localparam int INTV_C  = ((RETAIN_NS / ROWS) * 1000) / CLK_PS;
   localparam int SETUP_C = imax(ns_to_cyc(T_CSR_NS, CLK_PS), ns_to_cyc(T_WRP_NS, CLK_PS));
   localparam int HOLD_C  = imax(ns_to_cyc(T_CHR_NS, CLK_PS), ns_to_cyc(T_WRH_NS, CLK_PS));
   localparam int RAS_C   = imax(ns_to_cyc(T_RAS_NS, CLK_PS), HOLD_C + 1);
   localparam int PRE_C   = imax(ns_to_cyc(T_RP_NS, CLK_PS), ns_to_cyc(T_RC_NS, CLK_PS) - RAS_C);
   localparam int CYC_C   = SETUP_C + RAS_C + PRE_C;
   localparam int WARM_W  = $clog2(WARM_N + 2);

   if (INTV_C <= CYC_C + 1) begin : g_bad_interval
      $error("dram_refresh_sched: refresh interval shorter than one refresh cycle");
   end
   if (WARM_N < 0) begin : g_bad_warm
      $error("dram_refresh_sched: WARM_N must not be negative");
   end

   phase_t            phase;
   logic [WARM_W-1:0] warm_cnt;
   logic              pause_tick, intv_tick, pend, need, eng_start, eng_done;

   rfsh_tick_timer #(.LIMIT(INIT_C)) u_pause (
      .clk(clk), .rst_n(rst_n), .en(phase == PH_PAUSE), .tick(pause_tick));

   rfsh_tick_timer #(.LIMIT(INTV_C)) u_intv (
      .clk(clk), .rst_n(rst_n), .en(phase == PH_RUN), .tick(intv_tick));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_PAUSE;
         warm_cnt <= '0;
      end else begin
         case (phase)
            PH_PAUSE: if (pause_tick) phase <= (WARM_N == 0) ? PH_RUN : PH_WARM;
            PH_WARM:  if (eng_done) begin
                         warm_cnt <= warm_cnt + 1'b1;
                         if (warm_cnt == WARM_W'(WARM_N - 1)) phase <= PH_RUN;
                      end
            default:  phase <= PH_RUN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         pend <= 1'b0;
      else if (intv_tick) pend <= 1'b1;
      else if (eng_start) pend <= 1'b0;
   end

   assign need  = (phase == PH_WARM) || ((phase == PH_RUN) && pend);
   assign ready = (phase == PH_RUN);

   rfsh_cbr_engine #(
      .LANES(LANES), .SETUP_C(SETUP_C), .HOLD_C(HOLD_C),
      .RAS_C(RAS_C), .PRE_C(PRE_C)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .need(need), .bus_gnt(bus_gnt),
      .bus_req(bus_req), .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .start(eng_start), .done(eng_done));

   assert_quiet_during_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PAUSE) |-> !bus_req && ras_n);

   assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   assert_warm_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WARM) |-> (warm_cnt < WARM_W'(WARM_N)));

   assert_due_not_lost_R4: assert property (@(posedge clk) disable iff (!rst_n)
      intv_tick |=> pend);

endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
   localparam int CLK_PS = 10000;
   localparam int INIT_NS = 2000;
   localparam int WARM_N = 8;
   localparam int ROWS = 16;
   localparam int RETAIN_NS = 12800;

   function automatic int cdiv(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // expected figures from the requirement text (10 ns clock)
   localparam int INIT = cdiv(INIT_NS * 1000, CLK_PS);
   localparam int INTV = (RETAIN_NS / ROWS) * 1000 / CLK_PS;
   localparam int S = cdiv(10000, CLK_PS);
   localparam int H = cdiv(10000, CLK_PS);
   localparam int R = mx(cdiv(50000, CLK_PS), H + 1);
   localparam int P = mx(cdiv(30000, CLK_PS), cdiv(84000, CLK_PS) - R);
   localparam int L = S + R + P;

   logic clk = 0, rst_n = 0, bus_gnt = 0;
   logic bus_req, bus_own, ras_n, we_n, ready;
   logic [3:0] cas_n;

   always #5 clk = ~clk;

   dram_refresh_sched #(.CLK_PS(CLK_PS), .INIT_NS(INIT_NS), .WARM_N(WARM_N),
      .ROWS(ROWS), .RETAIN_NS(RETAIN_NS)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
      .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready));

   int vectors = 0, fails = 0, cyc = 0;

   // reference model: phase 0 pause, 1 warm-up, 2 running
   int m_phase, m_pc, m_wd, m_ic, m_eng, m_pos;
   bit m_pend;

   always @(posedge clk) begin : model
      bit need, done, start, tick;
      if (!rst_n) begin
         m_phase = 0; m_pc = 0; m_wd = 0; m_ic = 0; m_eng = 0; m_pos = 0; m_pend = 0;
      end else begin
         need  = (m_phase == 1) || (m_phase == 2 && m_pend);
         done  = (m_eng == 2) && (m_pos == L - 1);
         start = (m_eng == 1) && bus_gnt;
         tick  = (m_phase == 2) && (m_ic == INTV - 1);
         if (m_phase == 2) m_ic = tick ? 0 : m_ic + 1;
         if (tick) m_pend = 1; else if (start) m_pend = 0;
         case (m_phase)
            0: if (m_pc == INIT - 1) m_phase = (WARM_N == 0) ? 2 : 1; else m_pc++;
            1: if (done) begin
                  if (m_wd == WARM_N - 1) m_phase = 2;
                  m_wd++;
               end
            default: ;
         endcase
         if (m_eng == 0) begin if (need) m_eng = 1; end
         else if (m_eng == 1) begin if (start) begin m_eng = 2; m_pos = 0; end end
         else if (done) m_eng = 0;
         else m_pos++;
      end
   end

   task automatic check(input string tag, input string sig, input logic [3:0] act, input logic [3:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, sig, cyc, act, exp);
      end
   endtask

   // compare on the falling edge, after the model has advanced
   always @(negedge clk) begin : compare
      bit lo_r, lo_c;
      string tq;
      cyc++;
      lo_r = (m_eng == 2) && (m_pos >= S) && (m_pos < S + R);
      lo_c = (m_eng == 2) && (m_pos < S + H);
      if (!rst_n) tq = "R9";
      else if (m_phase == 0) tq = "R1";
      else if (m_phase == 1) tq = "R2";
      else tq = "R4";
      check(!rst_n ? "R9" : "R3", "ready", {3'b0, ready}, {3'b0, m_phase == 2});
      check(tq, "bus_req", {3'b0, bus_req}, {3'b0, m_eng != 0});
      check(!rst_n ? "R9" : "R7", "bus_own", {3'b0, bus_own}, {3'b0, m_eng == 2});
      check(!rst_n ? "R9" : (m_pos >= S + R ? "R8" : "R5"), "ras_n", {3'b0, ras_n}, {3'b0, !lo_r});
      check(!rst_n ? "R9" : "R5", "cas_n", cas_n, lo_c ? 4'h0 : 4'hF);
      check(!rst_n ? "R9" : "R6", "we_n", {3'b0, we_n}, 4'h1);
   end

   // access sequencer stand-in: grants after a varying delay (R7, R4 merging)
   int dly [8] = '{0, 2, 0, 5, 170, 1, 0, 3};
   int k = 0, wcnt = 0;
   always @(negedge clk) begin
      if (!bus_req) begin
         bus_gnt = 0; wcnt = 0;
      end else if (!bus_gnt) begin
         if (wcnt >= dly[k]) begin bus_gnt = 1; k = (k + 1) % 8; end
         else wcnt++;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      fork
         begin : run
            repeat (2500) @(negedge clk);
         end
         begin : watchdog
            repeat (100000) @(negedge clk);
            fails++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule